// File: doc/BRIEF.md
# Misaligned Access Trap Unit

This unit sits beside the execute stage of a 32-bit base-integer core that runs in machine mode only and has no compressed-instruction support. In that configuration every instruction is four bytes long and must start on a four-byte boundary. The unit checks the computed target of each jump and taken branch, and the effective address of each load and store. When one of them is misaligned, it raises the matching exception in the same cycle. That exception sends the next fetch to the trap vector base and suppresses the side effects of the faulting instruction. One cycle later the unit writes the exception PC, the cause and the trap value for the CSR file.

Each cycle presents either one control transfer or one memory access. A control transfer that traps is caught before its target is fetched: the redirect goes to the vector base and never to the bad target. A taken control transfer that does not trap passes its target out as the redirect. Memory accesses are not split or repaired in hardware. Any halfword or word access that is not naturally aligned is reported as an exception, and software handles it.

The unit also holds the machine ISA register. Its fixed value after reset advertises a 32-bit machine with only the base integer extension.

Top module: `misalign_trap_unit`

## Requirements
- R1: When `ctl_valid_i` is high and the transfer is taken (a jump, or a branch with `br_taken_i` high), the unit raises `trap_o` in the same cycle if bit 1 of the effective target is set. Only bit 1 is examined.
- R2: A cycle after any trap, `mepc_o` holds the `pc_i` of the faulting instruction. `mtval_o` holds the effective control target for an instruction fault, or `mem_addr_i` for a memory fault.
- R3: For JALR (`is_jalr_i` high), bit 0 of the target is cleared before the check. The cleared value is also the one used for the redirect and for `mtval_o`. A target whose bit 0 is set and bit 1 is clear does not trap.
- R4: A branch with `br_taken_i` low never traps and never redirects, whatever its target.
- R5: When `mem_valid_i` is high and `ctl_valid_i` is low, the access is misaligned if its address is not a multiple of the access size. `mem_size_i` encodes the size as 0 for byte, 1 for halfword and 2 or 3 for word. A misaligned load raises `trap_o` with cause 4. A misaligned store raises it with cause 6. While `ctl_valid_i` is high, the memory inputs are ignored.
- R6: A byte access (`mem_size_i` = 0) never traps, at any address.
- R7: While `trap_o` is high, `rd_we_o` and `mem_we_o` are low. Otherwise they follow `rd_we_i` and `mem_we_i`.
- R8: On a trap, `redirect_valid_o` is high and `redirect_pc_o` is `mtvec_i` with bits 1:0 cleared. On a taken transfer that does not trap, `redirect_pc_o` is the effective target. With no trap and no taken transfer, `redirect_valid_o` is low.
- R9: `csr_we_o` pulses high for exactly the cycle after each trap. `mcause_o` then holds 0 for an instruction fault, 4 for a load fault or 6 for a store fault, with bit 31 clear. `mepc_o`, `mcause_o` and `mtval_o` keep their values between traps.
- R10: After reset, `misa_o` reads 0x40000100.
- R11: After reset, `csr_we_o`, `mepc_o`, `mcause_o` and `mtval_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | PC of the instruction in execute |
| ctl_valid_i | input | 1 | Instruction is a jump or a branch |
| is_branch_i | input | 1 | Control transfer is a conditional branch |
| br_taken_i | input | 1 | Branch condition resolved true |
| is_jalr_i | input | 1 | Control transfer is a register-indirect jump |
| ctl_target_i | input | 32 | Computed control-transfer target |
| mem_valid_i | input | 1 | Instruction is a load or a store |
| mem_store_i | input | 1 | Memory access is a store |
| mem_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| mem_addr_i | input | 32 | Effective memory address |
| rd_we_i | input | 1 | Register write request from execute |
| mem_we_i | input | 1 | Memory write strobe request from execute |
| mtvec_i | input | 32 | Current trap vector base register |
| trap_o | output | 1 | Misaligned exception raised this cycle |
| redirect_valid_o | output | 1 | Next fetch address is supplied |
| redirect_pc_o | output | 32 | Next fetch address |
| rd_we_o | output | 1 | Gated register write enable |
| mem_we_o | output | 1 | Gated memory write strobe |
| csr_we_o | output | 1 | Trap CSR write strobe |
| mepc_o | output | 32 | Exception PC write data |
| mcause_o | output | 32 | Cause write data |
| mtval_o | output | 32 | Trap value write data |
| misa_o | output | 32 | Machine ISA register value |

## Verification
The hardest case to reach from the ports is a JALR whose raw target has bit 0 set and bit 1 clear. It must redirect without trapping. The neighbouring raw value with both bits set must trap, and the reported trap value must have bit 0 cleared. The stimulus forces those exact low-bit patterns, along with a not-taken branch aimed at a misaligned target. A second hard case is a pair of faults in consecutive cycles, so that the registered CSR data is overwritten while the gated strobes of the next fault are being checked. Directed vectors open the run, and then a long stretch of weighted random traffic follows. That traffic varies the low address bits, the access sizes, and cycles in which a control transfer and a memory access are presented together.

// File: rtl/mat_pkg.sv
// Package: shared encodings for the misaligned access trap unit.
// Assumes a 32-bit machine-mode-only core without compressed instructions.
package mat_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRSV = 2'd3
    } acc_size_e;

    localparam int unsigned CAUSE_INSTR_MIS = 0;
    localparam int unsigned CAUSE_LOAD_MIS  = 4;
    localparam int unsigned CAUSE_STORE_MIS = 6;
endpackage

// File: rtl/mat_ctl_check.sv
// Control-transfer checker: forms the effective target (JALR drops bit 0),
// decides whether the transfer is taken and flags a target that is not
// four-byte aligned. Purely combinational; clk/rst_n serve the assertions.
module mat_ctl_check #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic            is_branch_i,
    input  logic            taken_i,
    input  logic            is_jalr_i,
    input  logic [XLEN-1:0] target_i,
    output logic            take_o,
    output logic [XLEN-1:0] eff_target_o,
    output logic            fault_o
);
    // Effective target and fault decision for the current transfer.
    always_comb begin
        eff_target_o = is_jalr_i ? {target_i[XLEN-1:1], 1'b0} : target_i;
        take_o       = valid_i && (!is_branch_i || taken_i);
        fault_o      = take_o && eff_target_o[1];
    end

    // R4
    nt_branch_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_branch_i && !taken_i) |-> !fault_o);

    // R3
    jalr_bit0_only_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_jalr_i && !is_branch_i && target_i[1:0] == 2'b01) |-> !fault_o);
endmodule

// File: rtl/mat_mem_check.sv
// Memory alignment checker: flags halfword accesses at odd addresses and
// word accesses off a four-byte boundary. Byte accesses always pass.
module mat_mem_check #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [1:0]      size_i,
    input  logic [XLEN-1:0] addr_i,
    output logic            fault_o
);
    import mat_pkg::*;

    acc_size_e size_e;

    // Natural-alignment test selected by access size.
    always_comb begin
        size_e = acc_size_e'(size_i);
        unique case (size_e)
            SZ_BYTE: fault_o = 1'b0;
            SZ_HALF: fault_o = valid_i && addr_i[0];
            default: fault_o = valid_i && (addr_i[1:0] != 2'b00);
        endcase
    end

    // R6
    byte_never_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0) |-> !fault_o);
endmodule

// File: rtl/mat_trap_csr.sv
// Trap CSR write stage: registers the exception PC, cause and trap value one
// cycle after a trap and pulses the write strobe; also holds the ISA register.
module mat_trap_csr #(
    parameter int          XLEN       = 32,
    parameter logic [31:0] MISA_RESET = 32'h4000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] cause_i,
    input  logic [XLEN-1:0] tval_i,
    output logic            csr_we_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mtval_o,
    output logic [XLEN-1:0] misa_o
);
    // Capture trap data; hold between traps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_we_o <= 1'b0;
            mepc_o   <= '0;
            mcause_o <= '0;
            mtval_o  <= '0;
            misa_o   <= XLEN'(MISA_RESET);
        end else begin
            csr_we_o <= trap_i;
            if (trap_i) begin
                mepc_o   <= pc_i;
                mcause_o <= cause_i;
                mtval_o  <= tval_i;
            end
        end
    end

    // R9
    csr_we_follows_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |=> csr_we_o);

    // R9
    cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we_o |-> (mcause_o == 0 || mcause_o == 4 || mcause_o == 6));
endmodule

// File: rtl/misalign_trap_unit.sv
// Top: misaligned access trap unit. One instruction per cycle is either a
// control transfer or a memory access; the control inputs take precedence.
// Trap and redirect are combinational; CSR write data follows a cycle later.
module misalign_trap_unit #(
    parameter int          XLEN       = 32,
    parameter logic [31:0] MISA_RESET = 32'h4000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pc_i,
    input  logic            ctl_valid_i,
    input  logic            is_branch_i,
    input  logic            br_taken_i,
    input  logic            is_jalr_i,
    input  logic [XLEN-1:0] ctl_target_i,
    input  logic            mem_valid_i,
    input  logic            mem_store_i,
    input  logic [1:0]      mem_size_i,
    input  logic [XLEN-1:0] mem_addr_i,
    input  logic            rd_we_i,
    input  logic            mem_we_i,
    input  logic [XLEN-1:0] mtvec_i,
    output logic            trap_o,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            rd_we_o,
    output logic            mem_we_o,
    output logic            csr_we_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mtval_o,
    output logic [XLEN-1:0] misa_o
);
    import mat_pkg::*;

    logic            take;
    logic [XLEN-1:0] eff_target;
    logic            ifault;
    logic            mfault_raw;
    logic            mfault;
    logic [XLEN-1:0] cause;
    logic [XLEN-1:0] tval;

    mat_ctl_check #(.XLEN(XLEN)) ctl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (ctl_valid_i),
        .is_branch_i  (is_branch_i),
        .taken_i      (br_taken_i),
        .is_jalr_i    (is_jalr_i),
        .target_i     (ctl_target_i),
        .take_o       (take),
        .eff_target_o (eff_target),
        .fault_o      (ifault)
    );

    mat_mem_check #(.XLEN(XLEN)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (mem_valid_i),
        .size_i  (mem_size_i),
        .addr_i  (mem_addr_i),
        .fault_o (mfault_raw)
    );

    // Trap selection, cause/value muxing, redirect and side-effect gating.
    always_comb begin
        mfault           = mfault_raw && !ctl_valid_i;
        trap_o           = ifault || mfault;
        if (ifault)
            cause = XLEN'(CAUSE_INSTR_MIS);
        else if (mem_store_i)
            cause = XLEN'(CAUSE_STORE_MIS);
        else
            cause = XLEN'(CAUSE_LOAD_MIS);
        tval             = ifault ? eff_target : mem_addr_i;
        redirect_valid_o = trap_o || take;
        redirect_pc_o    = trap_o ? {mtvec_i[XLEN-1:2], 2'b00} : eff_target;
        rd_we_o          = rd_we_i && !trap_o;
        mem_we_o         = mem_we_i && !trap_o;
    end

    mat_trap_csr #(.XLEN(XLEN), .MISA_RESET(MISA_RESET)) csr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap_i   (trap_o),
        .pc_i     (pc_i),
        .cause_i  (cause),
        .tval_i   (tval),
        .csr_we_o (csr_we_o),
        .mepc_o   (mepc_o),
        .mcause_o (mcause_o),
        .mtval_o  (mtval_o),
        .misa_o   (misa_o)
    );

    // R7
    no_side_effect_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (!rd_we_o && !mem_we_o));

    // R8
    trap_redirect_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (redirect_valid_o && redirect_pc_o[1:0] == 2'b00));

    // R2
    mepc_is_fault_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (mepc_o == $past(pc_i)));

    // R1
    never_fetch_bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |-> (redirect_pc_o[1] == 1'b0));
endmodule

// File: tb/misalign_trap_unit_tb_top.sv
module misalign_trap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = 0, ctl_target_i = 0, mem_addr_i = 0, mtvec_i = 0;
    logic        ctl_valid_i = 0, is_branch_i = 0, br_taken_i = 0, is_jalr_i = 0;
    logic        mem_valid_i = 0, mem_store_i = 0, rd_we_i = 0, mem_we_i = 0;
    logic [1:0]  mem_size_i = 0;
    logic        trap_o, redirect_valid_o, rd_we_o, mem_we_o, csr_we_o;
    logic [31:0] redirect_pc_o, mepc_o, mcause_o, mtval_o, misa_o;

    int checks = 0;
    int errors = 0;
    bit running = 0;

    // expected registered state
    logic        e_we = 0, n_we = 0;
    logic [31:0] e_pc = 0, e_cause = 0, e_val = 0, n_pc = 0, n_cause = 0, n_val = 0;

    always #2 clk = ~clk;

    misalign_trap_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .ctl_valid_i(ctl_valid_i),
        .is_branch_i(is_branch_i), .br_taken_i(br_taken_i), .is_jalr_i(is_jalr_i),
        .ctl_target_i(ctl_target_i), .mem_valid_i(mem_valid_i), .mem_store_i(mem_store_i),
        .mem_size_i(mem_size_i), .mem_addr_i(mem_addr_i), .rd_we_i(rd_we_i),
        .mem_we_i(mem_we_i), .mtvec_i(mtvec_i), .trap_o(trap_o),
        .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
        .rd_we_o(rd_we_o), .mem_we_o(mem_we_o), .csr_we_o(csr_we_o),
        .mepc_o(mepc_o), .mcause_o(mcause_o), .mtval_o(mtval_o), .misa_o(misa_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, compared at every falling edge
    always @(negedge clk) begin
        if (running) begin
            logic [31:0] t, rp;
            logic take, ifl, mfl, trp, rv;
            int align;
            check("R9 csr_we", {31'b0, csr_we_o}, {31'b0, e_we});
            check("R2 mepc", mepc_o, e_pc);
            check("R9 mcause", mcause_o, e_cause);
            check("R2 mtval", mtval_o, e_val);
            check("R10 misa", misa_o, 32'h4000_0100);
            t     = is_jalr_i ? (ctl_target_i & ~32'd1) : ctl_target_i;   // R3
            take  = ctl_valid_i && (!is_branch_i || br_taken_i);          // R4
            ifl   = take && ((t % 4) >= 2);                               // R1
            align = (mem_size_i == 0) ? 1 : (mem_size_i == 1) ? 2 : 4;    // R6
            mfl   = mem_valid_i && !ctl_valid_i && ((mem_addr_i % align) != 0); // R5
            trp   = ifl || mfl;
            rv    = trp || take;
            rp    = trp ? (mtvec_i & ~32'd3) : t;
            check("R1/R5 trap", {31'b0, trp_o_w()}, {31'b0, trp});
            check("R8 redirect_valid", {31'b0, redirect_valid_o}, {31'b0, rv});
            if (rv) check("R8 redirect_pc", redirect_pc_o, rp);
            check("R7 rd_we", {31'b0, rd_we_o}, {31'b0, rd_we_i && !trp});
            check("R7 mem_we", {31'b0, mem_we_o}, {31'b0, mem_we_i && !trp});
            n_we = trp;
            if (trp) begin
                n_pc    = pc_i;
                n_cause = ifl ? 32'd0 : (mem_store_i ? 32'd6 : 32'd4);
                n_val   = ifl ? t : mem_addr_i;
            end
        end
    end

    function automatic logic trp_o_w();
        return trap_o;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_we <= 0; e_pc <= 0; e_cause <= 0; e_val <= 0;
            n_we <= 0; n_pc <= 0; n_cause <= 0; n_val <= 0;
        end else begin
            e_we <= n_we; e_pc <= n_pc; e_cause <= n_cause; e_val <= n_val;
        end
    end

    task automatic idle();
        ctl_valid_i = 0; is_branch_i = 0; br_taken_i = 0; is_jalr_i = 0;
        mem_valid_i = 0; mem_store_i = 0; rd_we_i = 0; mem_we_i = 0;
    endtask

    task automatic ctl(input logic [31:0] pc, input logic br, input logic tk,
                       input logic jr, input logic [31:0] tg);
        @(posedge clk); #1;
        idle();
        pc_i = pc; ctl_valid_i = 1; is_branch_i = br; br_taken_i = tk;
        is_jalr_i = jr; ctl_target_i = tg; rd_we_i = !br;
    endtask

    task automatic mem(input logic [31:0] pc, input logic st, input logic [1:0] sz,
                       input logic [31:0] a);
        @(posedge clk); #1;
        idle();
        pc_i = pc; mem_valid_i = 1; mem_store_i = st; mem_size_i = sz;
        mem_addr_i = a; rd_we_i = !st; mem_we_i = st;
    endtask

    initial begin
        mtvec_i = 32'h0000_8001;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state, R10 misa
        check("R11 csr_we reset", {31'b0, csr_we_o}, 32'd0);
        check("R11 mepc reset", mepc_o, 32'd0);
        check("R11 mcause reset", mcause_o, 32'd0);
        check("R11 mtval reset", mtval_o, 32'd0);
        check("R10 misa reset", misa_o, 32'h4000_0100);
        rst_n = 1;
        running = 1;
        ctl(32'h100, 0, 0, 0, 32'h206);      // R1 jal to 2-aligned target
        ctl(32'h104, 0, 0, 0, 32'h208);      // aligned jal
        ctl(32'h108, 0, 0, 1, 32'h301);      // R3 jalr bit0 only, no trap
        ctl(32'h10c, 0, 0, 1, 32'h303);      // R3 jalr traps, tval 0x302
        ctl(32'h110, 1, 0, 0, 32'h402);      // R4 not-taken branch
        ctl(32'h114, 1, 1, 0, 32'h40a);      // R1 taken branch trap
        mem(32'h118, 0, 1, 32'h1001);        // R5 load half odd
        mem(32'h11c, 1, 2, 32'h1002);        // R5 store word, back to back
        mem(32'h120, 0, 0, 32'h1003);        // R6 byte
        mem(32'h124, 1, 0, 32'h1007);        // R6 byte store
        mem(32'h128, 0, 2, 32'h1004);        // aligned word load
        mem(32'h12c, 1, 3, 32'h1006);        // size 3 word store
        @(posedge clk); #1;
        idle();
        ctl_valid_i = 1; ctl_target_i = 32'h500; mem_valid_i = 1;
        mem_size_i = 2; mem_addr_i = 32'h3; mem_we_i = 1; // R5 memory ignored
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            idle();
            pc_i = $urandom & ~32'd3;
            mtvec_i = $urandom;
            if (($urandom % 8) == 0) mtvec_i = mtvec_i | 32'd3;
            ctl_valid_i = ($urandom % 5) < 2;
            is_branch_i = $urandom; br_taken_i = $urandom;
            is_jalr_i = !is_branch_i && $urandom;
            ctl_target_i = $urandom;
            mem_valid_i = ($urandom % 2) == 1;
            mem_store_i = $urandom; mem_size_i = $urandom;
            mem_addr_i = $urandom;
            rd_we_i = $urandom; mem_we_i = $urandom;
        end
        @(posedge clk); #1;
        idle();
        repeat (2) @(posedge clk);
        #1;
        running = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule